// File: doc/BRIEF.md
# Nonvolatile Store and Recall Sequencer

This block sits behind a serial command front end and owns two word arrays: a volatile working RAM that the host reads and writes, and a shadow array that stands in for nonvolatile storage. It moves the whole image between the two. After power-up it fills the RAM from the shadow array without being asked. On request it copies the RAM into the shadow array (a store) or the shadow array back into the RAM (a recall). Both copies take one word per clock. A store is followed by a programmable wait that models the write time.

Three latches guard against storing bad data. One is set by the host's write-enable command. One arms the automatic store. The third records that an explicit recall has run since power-up. A store of either kind goes ahead only if the write-enable latch and the recall-done latch are both set. The power-up fill does not set the recall-done latch, so nothing can be stored until the host runs a software recall or pulls the hardware recall pin. When the autostore latch is armed, a rising edge on the supply-low input starts a store. A `busy` output marks every sequence, and while it is high all commands and host RAM writes are dropped.

Top module: `nvstore_ctrl`

## Requirements
- R1: While `rst_n` is low, `busy` is 1 and the write-enable, autostore and recall-done latches all read 0.
- R2: After reset is released, `busy` stays high for exactly PUR_CYCLES samples, counted from the release. Every RAM word then equals the shadow word at the same address, and `recalled_latch` remains 0.
- R3: While `busy` is high, latch commands, store and recall strobes and host RAM writes have no effect.
- R4: While idle, `cmd_wren_set` sets `wren_latch` and `cmd_wren_clr` clears it. When both are pulsed in the same cycle, the clear wins.
- R5: If `wren_latch` or `recalled_latch` is 0, a store request is dropped: `busy` stays 0 and the shadow array is unchanged.
- R6: A `cmd_recall` pulse while idle raises `busy` for WORDS cycles, copies every shadow word into the RAM and sets `recalled_latch`.
- R7: A falling edge on `recall_pin_n` while idle has the same effect as R6.
- R8: An allowed `cmd_store` raises `busy` for WORDS+STORE_WAIT cycles, copies every RAM word into the shadow array and leaves `wren_latch` at 0 when it finishes.
- R9: `cmd_autostore_en` sets `autostore_latch`. A rising edge on `supply_low` starts the R8 store only if `autostore_latch` is set and the R5 condition allows it; otherwise the edge is ignored.
- R10: When several sequence requests are accepted in the same idle cycle, the accepted autostore runs first, then recall, then software store. Only one sequence runs; the others are dropped.
- R11: While idle, `host_we` writes `host_wdata` at `host_waddr`. `host_rdata` shows the word at `host_raddr` in the same cycle (RD_REG=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| cmd_wren_set | input | 1 | Strobe: set write-enable latch |
| cmd_wren_clr | input | 1 | Strobe: clear write-enable latch |
| cmd_autostore_en | input | 1 | Strobe: arm autostore latch |
| cmd_store | input | 1 | Strobe: software store request |
| cmd_recall | input | 1 | Strobe: software recall request |
| recall_pin_n | input | 1 | Hardware recall pin, acts on its falling edge |
| supply_low | input | 1 | Supply-low indication, acts on its rising edge |
| host_we | input | 1 | Host RAM write enable |
| host_waddr | input | AW | Host RAM write address |
| host_wdata | input | WIDTH | Host RAM write data |
| host_raddr | input | AW | Host RAM read address |
| host_rdata | output | WIDTH | Host RAM read data |
| busy | output | 1 | A sequence is running; commands are ignored |
| wren_latch | output | 1 | Write-enable latch state |
| autostore_latch | output | 1 | Autostore latch state |
| recalled_latch | output | 1 | Recall-done latch state |

## Verification
A strobe driven before clock edge N takes effect at that edge. `busy` can therefore first be seen high at the falling edge after N, and it stays high for exactly WORDS samples for a recall, WORDS+STORE_WAIT for a store, and zero for a dropped or latch-only command. The bench counts `busy` samples on falling edges starting at that point and compares the count with the expected length. It checks latches and reads back RAM words only at the falling edge where `busy` has returned low, so every sequence has finished by the time its result is compared. The power-up window is counted from the falling edge that releases reset, which gives PUR_CYCLES samples.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

   typedef enum logic [2:0] {
      ST_PWRUP,
      ST_IDLE,
      ST_RECALL,
      ST_STORE,
      ST_SWAIT
   } nvs_state_e;

   function automatic int nvs_cnt_bits(input int a, input int b, input int c);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      return $clog2(m + 1);
   endfunction

endpackage

// File: rtl/nvs_edge.sv
module nvs_edge #(
   parameter bit RISING = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic pulse
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RISING;
      else        prev_q <= din;
   end

   generate
      if (RISING) begin : g_rise
         assign pulse = din & ~prev_q;
      end else begin : g_fall
         assign pulse = ~din & prev_q;
      end
   endgenerate
endmodule

// File: rtl/nvs_latches.sv
module nvs_latches (
   input  logic clk,
   input  logic rst_n,
   input  logic idle,
   input  logic wren_set,
   input  logic wren_clr,
   input  logic as_set,
   input  logic store_done,
   input  logic recall_done,
   output logic wel,
   output logic asel,
   output logic prl
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel  <= 1'b0;
         asel <= 1'b0;
         prl  <= 1'b0;
      end else begin
         if (store_done)
            wel <= 1'b0;
         else if (idle && wren_clr)
            wel <= 1'b0;
         else if (idle && wren_set)
            wel <= 1'b1;
         if (idle && as_set)
            asel <= 1'b1;
         if (recall_done)
            prl <= 1'b1;
      end
   end
endmodule

// File: rtl/nvs_seq.sv
module nvs_seq
   import nvs_pkg::*;
#(
   parameter int WORDS      = 16,
   parameter int PUR_CYCLES = 40,
   parameter int STORE_WAIT = 8,
   localparam int AW = $clog2(WORDS),
   localparam int CW = nvs_cnt_bits(WORDS, PUR_CYCLES, STORE_WAIT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          can_store,
   input  logic          asel,
   input  logic          supply_edge,
   input  logic          recall_req,
   input  logic          store_req,
   output nvs_state_e    state,
   output logic [AW-1:0] idx,
   output logic          copy_to_ram,
   output logic          copy_to_nv,
   output logic          recall_done,
   output logic          store_done,
   output logic          idle
);
   localparam logic [CW-1:0] W_LAST   = CW'(WORDS - 1);
   localparam logic [CW-1:0] PUR_LAST = CW'(PUR_CYCLES - 1);
   localparam logic [CW-1:0] SW_LAST  = CW'(STORE_WAIT - 1);

   logic [CW-1:0] cnt;
   logic          auto_go;
   logic          sw_go;

   assign auto_go = supply_edge & asel & can_store;
   assign sw_go   = store_req & can_store;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_PWRUP;
         cnt   <= '0;
      end else begin
         unique case (state)
            ST_PWRUP: begin
               if (cnt == PUR_LAST) begin
                  state <= ST_IDLE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_IDLE: begin
               cnt <= '0;
               if (auto_go)         state <= ST_STORE;
               else if (recall_req) state <= ST_RECALL;
               else if (sw_go)      state <= ST_STORE;
            end
            ST_RECALL: begin
               if (cnt == W_LAST) begin
                  state <= ST_IDLE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_STORE: begin
               if (cnt == W_LAST) begin
                  state <= ST_SWAIT;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_SWAIT: begin
               if (cnt == SW_LAST) begin
                  state <= ST_IDLE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               state <= ST_IDLE;
               cnt   <= '0;
            end
         endcase
      end
   end

   assign idx         = cnt[AW-1:0];
   assign idle        = (state == ST_IDLE);
   assign copy_to_ram = ((state == ST_PWRUP) && (cnt <= W_LAST)) || (state == ST_RECALL);
   assign copy_to_nv  = (state == ST_STORE);
   assign recall_done = (state == ST_RECALL) && (cnt == W_LAST);
   assign store_done  = (state == ST_SWAIT) && (cnt == SW_LAST);
endmodule

// File: rtl/nvs_arrays.sv
module nvs_arrays #(
   parameter int WORDS  = 16,
   parameter int WIDTH  = 16,
   parameter bit RD_REG = 1'b0,
   localparam int AW = $clog2(WORDS)
) (
   input  logic             clk,
   input  logic             host_ok,
   input  logic             host_we,
   input  logic [AW-1:0]    host_waddr,
   input  logic [WIDTH-1:0] host_wdata,
   input  logic [AW-1:0]    host_raddr,
   output logic [WIDTH-1:0] host_rdata,
   input  logic             copy_to_ram,
   input  logic             copy_to_nv,
   input  logic [AW-1:0]    idx
);
   logic [WIDTH-1:0] ram_q [WORDS];
   logic [WIDTH-1:0] nv_q  [WORDS];

   always_ff @(posedge clk) begin
      if (copy_to_ram)
         ram_q[idx] <= nv_q[idx];
      else if (host_ok && host_we)
         ram_q[host_waddr] <= host_wdata;
   end

   always_ff @(posedge clk) begin
      if (copy_to_nv)
         nv_q[idx] <= ram_q[idx];
   end

   generate
      if (RD_REG) begin : g_rd_reg
         logic [WIDTH-1:0] rd_q;
         always_ff @(posedge clk) rd_q <= ram_q[host_raddr];
         assign host_rdata = rd_q;
      end else begin : g_rd_comb
         assign host_rdata = ram_q[host_raddr];
      end
   endgenerate
endmodule

// File: rtl/nvstore_ctrl.sv
module nvstore_ctrl
   import nvs_pkg::*;
#(
   parameter int WORDS      = 16,
   parameter int WIDTH      = 16,
   parameter int PUR_CYCLES = 40,
   parameter int STORE_WAIT = 8,
   parameter bit RD_REG     = 1'b0,
   localparam int AW = $clog2(WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_wren_set,
   input  logic             cmd_wren_clr,
   input  logic             cmd_autostore_en,
   input  logic             cmd_store,
   input  logic             cmd_recall,
   input  logic             recall_pin_n,
   input  logic             supply_low,
   input  logic             host_we,
   input  logic [AW-1:0]    host_waddr,
   input  logic [WIDTH-1:0] host_wdata,
   input  logic [AW-1:0]    host_raddr,
   output logic [WIDTH-1:0] host_rdata,
   output logic             busy,
   output logic             wren_latch,
   output logic             autostore_latch,
   output logic             recalled_latch
);
   generate
      if (WORDS < 2) begin : g_bad_words
         $error("WORDS must be at least 2");
      end
      if (PUR_CYCLES < WORDS) begin : g_bad_pur
         $error("PUR_CYCLES must cover one full copy of WORDS");
      end
      if (STORE_WAIT < 1) begin : g_bad_wait
         $error("STORE_WAIT must be at least 1");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("WIDTH must be positive");
      end
   endgenerate

   nvs_state_e    seq_state;
   logic [AW-1:0] idx;
   logic          copy_to_ram, copy_to_nv;
   logic          recall_done, store_done, idle;
   logic          supply_edge, pin_edge;

   nvs_edge #(.RISING(1'b1)) i_supply_edge (
      .clk(clk), .rst_n(rst_n), .din(supply_low), .pulse(supply_edge)
   );

   nvs_edge #(.RISING(1'b0)) i_pin_edge (
      .clk(clk), .rst_n(rst_n), .din(recall_pin_n), .pulse(pin_edge)
   );

   nvs_seq #(
      .WORDS(WORDS), .PUR_CYCLES(PUR_CYCLES), .STORE_WAIT(STORE_WAIT)
   ) i_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .can_store   (wren_latch & recalled_latch),
      .asel        (autostore_latch),
      .supply_edge (supply_edge),
      .recall_req  (cmd_recall | pin_edge),
      .store_req   (cmd_store),
      .state       (seq_state),
      .idx         (idx),
      .copy_to_ram (copy_to_ram),
      .copy_to_nv  (copy_to_nv),
      .recall_done (recall_done),
      .store_done  (store_done),
      .idle        (idle)
   );

   nvs_latches i_latches (
      .clk         (clk),
      .rst_n       (rst_n),
      .idle        (idle),
      .wren_set    (cmd_wren_set),
      .wren_clr    (cmd_wren_clr),
      .as_set      (cmd_autostore_en),
      .store_done  (store_done),
      .recall_done (recall_done),
      .wel         (wren_latch),
      .asel        (autostore_latch),
      .prl         (recalled_latch)
   );

   nvs_arrays #(
      .WORDS(WORDS), .WIDTH(WIDTH), .RD_REG(RD_REG)
   ) i_arrays (
      .clk         (clk),
      .host_ok     (idle),
      .host_we     (host_we),
      .host_waddr  (host_waddr),
      .host_wdata  (host_wdata),
      .host_raddr  (host_raddr),
      .host_rdata  (host_rdata),
      .copy_to_ram (copy_to_ram),
      .copy_to_nv  (copy_to_nv),
      .idx         (idx)
   );

   assign busy = ~idle;
endmodule

// File: rtl/nvstore_ctrl_chk.sv
module nvstore_ctrl_chk
   import nvs_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       busy,
   input logic       wel,
   input logic       asel,
   input logic       prl,
   input nvs_state_e state
);
   // R1
   reset_state_chk: assert property (@(posedge clk)
      !rst_n |=> (busy && !wel && !asel && !prl));

   // R2
   pwrup_keeps_prl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PWRUP) |-> !prl);

   // R5
   store_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state == ST_STORE) |-> $past(wel && prl));

   // R6
   prl_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prl) |-> $past(state == ST_RECALL));

   // R3
   busy_locks_asel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(asel));

   // R8
   store_clears_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(state == ST_SWAIT) |-> !wel);
endmodule

bind nvstore_ctrl nvstore_ctrl_chk i_nvstore_ctrl_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .busy  (busy),
   .wel   (wren_latch),
   .asel  (autostore_latch),
   .prl   (recalled_latch),
   .state (seq_state)
);

// File: tb/test_nvstore_ctrl.sv
`timescale 1ns/100ps
module test_nvstore_ctrl;
   localparam int WORDS = 16;
   localparam int WIDTH = 16;
   localparam int PUR   = 24;
   localparam int SW    = 5;
   localparam int AW    = $clog2(WORDS);

   localparam int OP_WRITE = 0, OP_WSET = 1, OP_WCLR = 2, OP_ASEN = 3,
                  OP_STORE = 4, OP_RECALL = 5, OP_PIN = 6, OP_AUTO = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_wren_set = 0, cmd_wren_clr = 0, cmd_autostore_en = 0;
   logic cmd_store = 0, cmd_recall = 0, recall_pin_n = 1, supply_low = 0;
   logic host_we = 0;
   logic [AW-1:0] host_waddr = '0, host_raddr = '0;
   logic [WIDTH-1:0] host_wdata = '0;
   logic [WIDTH-1:0] host_rdata;
   logic busy, wren_latch, autostore_latch, recalled_latch;

   int checks = 0;
   int errors = 0;
   logic [WIDTH-1:0] m_ram [WORDS];
   logic [WIDTH-1:0] m_nv  [WORDS];
   bit m_wel = 0, m_asel = 0, m_prl = 0;

   always #2.5 clk = ~clk;

   nvstore_ctrl #(
      .WORDS(WORDS), .WIDTH(WIDTH), .PUR_CYCLES(PUR), .STORE_WAIT(SW), .RD_REG(1'b0)
   ) i_nvstore_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cmd_wren_set(cmd_wren_set), .cmd_wren_clr(cmd_wren_clr),
      .cmd_autostore_en(cmd_autostore_en), .cmd_store(cmd_store),
      .cmd_recall(cmd_recall), .recall_pin_n(recall_pin_n), .supply_low(supply_low),
      .host_we(host_we), .host_waddr(host_waddr), .host_wdata(host_wdata),
      .host_raddr(host_raddr), .host_rdata(host_rdata),
      .busy(busy), .wren_latch(wren_latch), .autostore_latch(autostore_latch),
      .recalled_latch(recalled_latch)
   );

   task automatic chk(input string req, input bit ok, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit store_ok();
      return m_wel && m_prl;
   endfunction

   function automatic int exp_len(input int op);
      case (op)
         OP_RECALL, OP_PIN: return WORDS;
         OP_STORE:          return store_ok() ? WORDS + SW : 0;
         OP_AUTO:           return (m_asel && store_ok()) ? WORDS + SW : 0;
         default:           return 0;
      endcase
   endfunction

   task automatic chk_latches(input string req);
      chk({req, " wren"}, wren_latch == m_wel, wren_latch, m_wel);
      chk({req, " autostore"}, autostore_latch == m_asel, autostore_latch, m_asel);
      chk({req, " recalled"}, recalled_latch == m_prl, recalled_latch, m_prl);
   endtask

   task automatic chk_ram(input string req);
      for (int a = 0; a < WORDS; a++) begin
         host_raddr = AW'(a);
         #0.1;
         chk({req, " ram word"}, host_rdata == m_ram[a], host_rdata, m_ram[a]);
      end
   endtask

   // count busy samples, starting at the current falling edge
   task automatic measure_busy(output int n);
      n = 0;
      while (busy && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic clear_inputs();
      cmd_wren_set = 0; cmd_wren_clr = 0; cmd_autostore_en = 0;
      cmd_store = 0; cmd_recall = 0; recall_pin_n = 1; supply_low = 0; host_we = 0;
   endtask

   task automatic do_op(input int op, input string req);
      int n, e;
      logic [AW-1:0] a;
      logic [WIDTH-1:0] d;
      e = exp_len(op);
      a = AW'($urandom_range(0, WORDS - 1));
      d = WIDTH'($urandom);
      @(negedge clk);
      case (op)
         OP_WRITE:  begin host_we = 1; host_waddr = a; host_wdata = d; end
         OP_WSET:   cmd_wren_set = 1;
         OP_WCLR:   cmd_wren_clr = 1;
         OP_ASEN:   cmd_autostore_en = 1;
         OP_STORE:  cmd_store = 1;
         OP_RECALL: cmd_recall = 1;
         OP_PIN:    recall_pin_n = 0;
         default:   supply_low = 1;
      endcase
      @(negedge clk);
      clear_inputs();
      measure_busy(n);
      chk({req, " busy length"}, n == e, n, e);
      case (op)
         OP_WRITE:  m_ram[a] = d;
         OP_WSET:   m_wel = 1;
         OP_WCLR:   m_wel = 0;
         OP_ASEN:   m_asel = 1;
         OP_RECALL, OP_PIN: begin
            for (int i = 0; i < WORDS; i++) m_ram[i] = m_nv[i];
            m_prl = 1;
         end
         default: begin
            if (e != 0) begin
               for (int i = 0; i < WORDS; i++) m_nv[i] = m_ram[i];
               m_wel = 0;
            end
         end
      endcase
      chk_latches(req);
   endtask

   task automatic power_cycle(input string req);
      int n;
      @(negedge clk);
      rst_n = 0;
      @(negedge clk);
      chk({req, " R1 busy in reset"}, busy == 1'b1, busy, 1);
      m_wel = 0; m_asel = 0; m_prl = 0;
      chk_latches({req, " R1"});
      @(negedge clk);
      rst_n = 1;
      measure_busy(n);
      chk({req, " R2 power-up busy"}, n == PUR, n, PUR);
      chk_latches({req, " R2"});
   endtask

   initial begin : watchdog
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      int n;
      void'($urandom(32'h5EED));

      // R1, R2 first power-up (shadow content unknown: learn it)
      power_cycle("R2 first");
      for (int a = 0; a < WORDS; a++) begin
         host_raddr = AW'(a);
         #0.1;
         m_ram[a] = host_rdata;
         m_nv[a]  = host_rdata;
      end

      // R5 store blocked with no latches, then with recall-done still clear
      do_op(OP_STORE, "R5 no latches");
      do_op(OP_WSET, "R4 set");
      do_op(OP_STORE, "R5 recalled clear");

      // R7 hardware recall
      do_op(OP_PIN, "R7 pin recall");
      chk_ram("R7");

      // R11 host writes
      for (int a = 0; a < WORDS; a++) begin
         @(negedge clk);
         host_we = 1; host_waddr = AW'(a); host_wdata = WIDTH'(16'hA500 + a * 16'h0111);
         m_ram[a] = host_wdata;
      end
      @(negedge clk);
      host_we = 0;
      chk_ram("R11");

      // R8 store, then R6 recall brings it back
      do_op(OP_STORE, "R8 store");
      do_op(OP_WRITE, "R11 overwrite");
      do_op(OP_RECALL, "R6 recall");
      chk_ram("R6");

      // R3 commands during busy are ignored
      do_op(OP_WSET, "R4 set again");
      @(negedge clk);
      cmd_recall = 1;
      @(negedge clk);
      cmd_recall = 0; cmd_wren_clr = 1; cmd_autostore_en = 1;
      host_we = 1; host_waddr = AW'(3); host_wdata = 16'hDEAD;
      @(negedge clk);
      clear_inputs();
      measure_busy(n);
      chk("R3 recall length", n == WORDS - 1, n, WORDS - 1);
      chk_latches("R3 latches unchanged");
      chk_ram("R3 ram unchanged");

      // R9 supply edge without autostore armed is ignored
      do_op(OP_AUTO, "R9 not armed");
      do_op(OP_ASEN, "R9 arm");
      do_op(OP_WRITE, "R11 pre-auto");
      do_op(OP_AUTO, "R9 autostore");
      do_op(OP_WRITE, "R11 post-auto");
      do_op(OP_RECALL, "R9 verify");
      chk_ram("R9");

      // R4 simultaneous set and clear
      @(negedge clk);
      cmd_wren_set = 1; cmd_wren_clr = 1;
      @(negedge clk);
      clear_inputs();
      chk("R4 clear wins", wren_latch == 1'b0, wren_latch, 0);
      m_wel = 0;

      // R10 recall beats store
      do_op(OP_WSET, "R10 set");
      @(negedge clk);
      cmd_recall = 1; cmd_store = 1;
      @(negedge clk);
      clear_inputs();
      measure_busy(n);
      chk("R10 recall over store", n == WORDS, n, WORDS);
      chk_latches("R10 store dropped");

      // R10 autostore beats recall
      do_op(OP_WRITE, "R11 pre-prio");
      @(negedge clk);
      cmd_recall = 1; supply_low = 1;
      @(negedge clk);
      clear_inputs();
      measure_busy(n);
      chk("R10 autostore over recall", n == WORDS + SW, n, WORDS + SW);
      for (int i = 0; i < WORDS; i++) m_nv[i] = m_ram[i];
      m_wel = 0;
      chk_latches("R10 after autostore");
      chk_ram("R10 recall dropped");

      // R2 power-up recall restores stored image, recall-done clear
      do_op(OP_WRITE, "R11 pre-reset");
      power_cycle("R2 second");
      for (int i = 0; i < WORDS; i++) m_ram[i] = m_nv[i];
      chk_ram("R2 restored");

      // constrained random sequence
      for (int it = 0; it < 80; it++) begin
         int op;
         int r;
         r = $urandom_range(0, 99);
         if (r < 30)      op = OP_WRITE;
         else if (r < 45) op = OP_WSET;
         else if (r < 52) op = OP_WCLR;
         else if (r < 58) op = OP_ASEN;
         else if (r < 72) op = OP_STORE;
         else if (r < 82) op = OP_RECALL;
         else if (r < 90) op = OP_PIN;
         else             op = OP_AUTO;
         do_op(op, "R10 random");
         if (op == OP_RECALL || op == OP_PIN) chk_ram("R6 random");
      end
      chk_ram("R11 final");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule